// File: doc/BRIEF.md
# Per-Line Pulse/Level Interrupt Pending Unit

This block collects interrupt requests for a small processor core and keeps the vector of interrupts that are waiting for service. It has one pending bit for each raw request line. A build-time mode word gives each line one of two behaviours. A pulse line remembers a request that lasted a single cycle and keeps it until the core acknowledges it. A level line simply shows whether its input was high on the previous cycle. A second build-time word removes lines from service for good.

A countdown timer feeds one line, chosen by a parameter. Software loads the timer through a write port and it counts down by one each cycle. When a decrement takes it from one to zero, the timer's line becomes pending. A runtime mask register decides which pending lines may raise the single request output to the core. When the core enters its handler, it clears the serviced lines with an acknowledge vector. A build parameter can remove interrupt support completely, and that removes the timer with it.

Top module: `irq_pend_ctrl`

## Requirements
- R1: For a line whose bit is 1 in `LATCH_MASK`, a request that is high for one cycle sets that line's pending bit after the next clock edge. The bit then stays set, with no further input, until an acknowledge names it.
- R2: For a line whose bit is 0 in `LATCH_MASK`, the pending bit after each edge equals the input level sampled at that edge. It clears one cycle after the input falls.
- R3: A line whose bit is 1 in `DISABLE_MASK` never shows a pending bit of 1, whatever its input or the timer does.
- R4: When `ack_valid` is high, every pending bit whose bit is set in `ack_vec` is cleared at that edge. If the same line's request is high in that same cycle, the request wins and the bit stays set.
- R5: A cycle with `tmr_wr_en` high loads `tmr_wr_val` into the timer. Otherwise a nonzero timer decrements by one each cycle, and a timer at zero stays at zero. Loading zero stops the timer.
- R6: A cycle in which the timer holds 1 and no load happens sets pending bit `TIMER_LINE` (bit 0 by default) at that edge, as the timer reaches 0.
- R7: The runtime mask resets to all ones, and `mask_wr_en` loads `mask_wr_val` into it. A 1 in the mask blocks that line. `irq_req` is high exactly when some pending bit is 1 and its mask bit is 0, and it is aligned with the `pending` output.
- R8: A cycle with `rst` high clears the pending vector, the timer and `irq_req`, and sets the mask to all ones, at the next edge.
- R9: With `IRQ_EN` set to 0, `pending`, `irq_req` and `tmr_count` stay 0 under any input.
- R10: A load in the same cycle that the timer holds 1 takes priority. No timer event occurs, and the timer takes the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | NLINES | Raw request lines |
| ack_valid | input | 1 | Handler entry acknowledge strobe |
| ack_vec | input | NLINES | Lines being serviced |
| tmr_wr_en | input | 1 | Timer load strobe |
| tmr_wr_val | input | TW | Timer load value (0 stops the timer) |
| mask_wr_en | input | 1 | Runtime mask write strobe |
| mask_wr_val | input | NLINES | New runtime mask, 1 blocks the line |
| pending | output | NLINES | Registered pending vector |
| irq_req | output | 1 | Registered request to the core |
| tmr_count | output | TW | Current timer value |

## Verification
The bench builds the design with a mode word that mixes pulse lines, level lines and disabled lines. This lets one run show whether a bit is kept, follows its input, or is blocked. Directed patterns cover the following cases:
- single-cycle pulses, which separate pulse lines from level lines;
- held and dropped levels, which show a level bit clearing one cycle later;
- an acknowledge that coincides with a fresh request, which shows which of the two wins;
- timer loads that end at zero, are stopped with zero, or are reloaded while the timer holds one.

Sparse random requests, acknowledges, mask writes and timer loads are then checked cycle by cycle against a reference model in the bench. A second copy built with interrupts disabled must stay silent throughout.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int DEF_LINES = 32;
  localparam int DEF_TW    = 32;

  // one-hot select of a single line in a vector of n lines
  function automatic logic [DEF_LINES-1:0] line_bit(input int idx);
    logic [DEF_LINES-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irqp_cell.sv
module irqp_cell #(
  parameter bit KEEP = 1'b1,   // 1: pulse line held until acknowledge, 0: level line
  parameter bit DEAD = 1'b0,   // 1: line removed from service
  parameter bit EN   = 1'b1    // interrupt support present
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic clr,
  input  logic tev,
  output logic pend_n,
  output logic pend_q
);
  // held state survives only on pulse lines and only when not being cleared
  logic held;
  assign held   = KEEP && pend_q && !clr;
  assign pend_n = EN && !DEAD && (held || raw || tev);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_n;
  end
endmodule

// File: rtl/irqp_timer.sv
module irqp_timer #(
  parameter int TW = 32,
  parameter bit EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_val,
  output logic [TW-1:0] count,
  output logic          tick
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!EN)                cnt_n = '0;
    else if (wr_en)         cnt_n = wr_val;
    else if (cnt_q != '0)   cnt_n = cnt_q - ONE;
    else                    cnt_n = cnt_q;
  end

  // a load in the last cycle pre-empts the expiry
  assign tick  = EN && !wr_en && (cnt_q == ONE);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end
endmodule

// File: rtl/irqp_maskreg.sv
module irqp_maskreg #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NLINES-1:0] wr_val,
  output logic [NLINES-1:0] mask_n,
  output logic [NLINES-1:0] mask_q
);
  assign mask_n = wr_en ? wr_val : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_n;
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int                           NLINES       = irqp_pkg::DEF_LINES,
  parameter int                           TW           = irqp_pkg::DEF_TW,
  parameter logic [irqp_pkg::DEF_LINES-1:0] LATCH_MASK   = '1,
  parameter logic [irqp_pkg::DEF_LINES-1:0] DISABLE_MASK = '0,
  parameter bit                           IRQ_EN       = 1'b1,
  parameter int                           TIMER_LINE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              ack_valid,
  input  logic [NLINES-1:0] ack_vec,
  input  logic              tmr_wr_en,
  input  logic [TW-1:0]     tmr_wr_val,
  input  logic              mask_wr_en,
  input  logic [NLINES-1:0] mask_wr_val,
  output logic [NLINES-1:0] pending,
  output logic              irq_req,
  output logic [TW-1:0]     tmr_count
);
  logic              tick;
  logic [NLINES-1:0] clr_vec;
  logic [NLINES-1:0] pend_n;
  logic [NLINES-1:0] rt_mask_n;
  logic [NLINES-1:0] rt_mask;
  logic              req_q;

  assign clr_vec = ack_valid ? ack_vec : '0;

  irqp_timer #(.TW(TW), .EN(IRQ_EN)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (tmr_wr_en),
    .wr_val (tmr_wr_val),
    .count  (tmr_count),
    .tick   (tick)
  );

  irqp_maskreg #(.NLINES(NLINES)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mask_wr_en),
    .wr_val (mask_wr_val),
    .mask_n (rt_mask_n),
    .mask_q (rt_mask)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam bit IS_TMR = (i == TIMER_LINE);
    irqp_cell #(
      .KEEP (LATCH_MASK[i]),
      .DEAD (DISABLE_MASK[i]),
      .EN   (IRQ_EN)
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .raw    (irq_lines[i]),
      .clr    (clr_vec[i]),
      .tev    (IS_TMR ? tick : 1'b0),
      .pend_n (pend_n[i]),
      .pend_q (pending[i])
    );
  end

  // request registered from next-state values so it lines up with pending
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= |(pend_n & ~rt_mask_n);
  end
  assign irq_req = req_q;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int                             NLINES       = 32,
  parameter int                             TW           = 32,
  parameter logic [irqp_pkg::DEF_LINES-1:0] LATCH_MASK   = '1,
  parameter logic [irqp_pkg::DEF_LINES-1:0] DISABLE_MASK = '0,
  parameter bit                             IRQ_EN       = 1'b1,
  parameter int                             TIMER_LINE   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] irq_lines,
  input logic              ack_valid,
  input logic [NLINES-1:0] ack_vec,
  input logic              tmr_wr_en,
  input logic [TW-1:0]     tmr_count,
  input logic [NLINES-1:0] pending,
  input logic              irq_req,
  input logic [NLINES-1:0] rt_mask
);
  localparam logic [NLINES-1:0] LM   = LATCH_MASK[NLINES-1:0];
  localparam logic [NLINES-1:0] DM   = DISABLE_MASK[NLINES-1:0];
  localparam logic [NLINES-1:0] TBIT = NLINES'(1) << TIMER_LINE;
  localparam logic [NLINES-1:0] LVL  = IRQ_EN ? (~LM & ~DM & ~TBIT) : '0;
  localparam logic [NLINES-1:0] LA   = IRQ_EN ? (LM & ~DM & ~TBIT) : '0;

  assert_pulse_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!ack_valid) |=> ((($past(pending) & LA) & ~pending) == '0));

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & LVL) == ($past(irq_lines) & LVL)));

  assert_never_dead_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & DM) == '0));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> ((pending & $past(ack_vec) & ~$past(irq_lines) & LA) == '0));

  assert_timer_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!tmr_wr_en && tmr_count != '0) |=> (tmr_count == $past(tmr_count) - TW'(1)));

  assert_req_match_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req == |(pending & ~rt_mask));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (pending == '0 && !irq_req && tmr_count == '0));

  assert_off_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (!IRQ_EN) |-> (pending == '0 && tmr_count == '0));
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
  .NLINES       (NLINES),
  .TW           (TW),
  .LATCH_MASK   (LATCH_MASK),
  .DISABLE_MASK (DISABLE_MASK),
  .IRQ_EN       (IRQ_EN),
  .TIMER_LINE   (TIMER_LINE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_lines (irq_lines),
  .ack_valid (ack_valid),
  .ack_vec   (ack_vec),
  .tmr_wr_en (tmr_wr_en),
  .tmr_count (tmr_count),
  .pending   (pending),
  .irq_req   (irq_req),
  .rt_mask   (rt_mask)
);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  localparam int          NL = 32;
  localparam int          TW = 32;
  localparam logic [31:0] LM = 32'hFFFF_00FF;  // lines 8..15 level
  localparam logic [31:0] DM = 32'h8000_3000;  // lines 12,13,31 removed

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0] irq_lines, ack_vec, mask_wr_val;
  logic          ack_valid, tmr_wr_en, mask_wr_en;
  logic [TW-1:0] tmr_wr_val;
  logic [NL-1:0] pending, pending_off;
  logic          irq_req, irq_req_off;
  logic [TW-1:0] tmr_count, tmr_count_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R8";

  // model state
  logic [NL-1:0] m_pend, m_mask;
  logic [TW-1:0] m_cnt;
  logic          m_req;

  always #4 clk = ~clk;

  irq_pend_ctrl #(.NLINES(NL), .TW(TW), .LATCH_MASK(LM), .DISABLE_MASK(DM),
                  .IRQ_EN(1'b1), .TIMER_LINE(0)) u_irq_pend_ctrl (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .ack_valid(ack_valid),
    .ack_vec(ack_vec), .tmr_wr_en(tmr_wr_en), .tmr_wr_val(tmr_wr_val),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val),
    .pending(pending), .irq_req(irq_req), .tmr_count(tmr_count));

  irq_pend_ctrl #(.NLINES(NL), .TW(TW), .LATCH_MASK(LM), .DISABLE_MASK(DM),
                  .IRQ_EN(1'b0), .TIMER_LINE(0)) u_irq_pend_ctrl_off (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .ack_valid(ack_valid),
    .ack_vec(ack_vec), .tmr_wr_en(tmr_wr_en), .tmr_wr_val(tmr_wr_val),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val),
    .pending(pending_off), .irq_req(irq_req_off), .tmr_count(tmr_count_off));

  function automatic logic [TW-1:0] nxt_cnt(input logic [TW-1:0] c);
    if (rst)            return '0;
    if (tmr_wr_en)      return tmr_wr_val;
    if (c != '0)        return c - 1;
    return c;
  endfunction

  function automatic logic [NL-1:0] nxt_pend(input logic [NL-1:0] p, input logic [TW-1:0] c);
    logic [NL-1:0] n;
    logic ev;
    if (rst) return '0;
    ev = (c == 1) && !tmr_wr_en;
    n = (p & LM & ~(ack_valid ? ack_vec : '0)) | irq_lines | {31'b0, ev};
    return n & ~DM;
  endfunction

  function automatic logic [NL-1:0] nxt_mask(input logic [NL-1:0] m);
    if (rst) return '1;
    return mask_wr_en ? mask_wr_val : m;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle();
    rst = 0; irq_lines = '0; ack_valid = 0; ack_vec = '0;
    tmr_wr_en = 0; tmr_wr_val = '0; mask_wr_en = 0; mask_wr_val = '0;
  endtask

  // inputs are set before calling; advances one edge and compares everything
  task automatic step();
    logic [NL-1:0] p_n, mk_n;
    logic [TW-1:0] c_n;
    p_n  = nxt_pend(m_pend, m_cnt);
    c_n  = nxt_cnt(m_cnt);
    mk_n = nxt_mask(m_mask);
    @(posedge clk);
    #1;
    m_pend = p_n; m_cnt = c_n; m_mask = mk_n;
    m_req  = rst ? 1'b0 : |(p_n & ~mk_n);
    chk(pending == m_pend, tag, 64'(pending), 64'(m_pend));
    chk(irq_req == m_req, {tag, "/R7"}, 64'(irq_req), 64'(m_req));
    chk(tmr_count == m_cnt, {tag, "/R5"}, 64'(tmr_count), 64'(m_cnt));
    chk(pending_off == '0 && tmr_count_off == '0 && !irq_req_off, "R9",
        64'(pending_off), 64'(0));
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pend = '0; m_cnt = '0; m_mask = '1; m_req = 0;
    idle();
    rst = 1;
    @(negedge clk);
    rst = 1; step();
    rst = 1; step();
    chk(pending == '0 && !irq_req && tmr_count == '0, "R8", 64'(pending), 64'(0));

    // R7: masked by default, then unmask line 3
    tag = "R7";
    irq_lines[3] = 1; step();
    chk(!irq_req && pending[3], "R7", 64'(irq_req), 64'(0));
    mask_wr_en = 1; mask_wr_val = ~(32'h8); step();
    chk(irq_req, "R7", 64'(irq_req), 64'(1));

    // R1: single pulse on a latched line holds
    tag = "R1";
    irq_lines[5] = 1; step();
    for (int k = 0; k < 4; k++) step();
    chk(pending[5], "R1", 64'(pending[5]), 64'(1));

    // R2: level line follows input, clears one cycle after drop
    tag = "R2";
    irq_lines[9] = 1; step();
    irq_lines[9] = 1; step();
    chk(pending[9], "R2", 64'(pending[9]), 64'(1));
    step();
    chk(!pending[9], "R2", 64'(pending[9]), 64'(0));

    // R3: removed lines never set
    tag = "R3";
    irq_lines = DM; step();
    irq_lines = DM; step();
    chk((pending & DM) == '0, "R3", 64'(pending), 64'(pending & ~DM));

    // R4: acknowledge clears, coincident request wins
    tag = "R4";
    ack_valid = 1; ack_vec = 32'h28; irq_lines[3] = 1; step();
    chk(!pending[5] && pending[3], "R4", 64'(pending & 32'h28), 64'h8);
    ack_valid = 1; ack_vec = 32'h8; step();
    chk(!pending[3] && !irq_req, "R4", 64'(pending[3]), 64'(0));

    // R5/R6: countdown to an event on line 0
    tag = "R6";
    tmr_wr_en = 1; tmr_wr_val = 4; step();
    chk(tmr_count == 4, "R5", 64'(tmr_count), 64'd4);
    for (int k = 0; k < 4; k++) step();
    chk(tmr_count == 0 && pending[0], "R6", 64'(pending[0]), 64'(1));
    ack_valid = 1; ack_vec = 32'h1; step();
    tag = "R5";
    tmr_wr_en = 1; tmr_wr_val = 5; step();
    step();
    tmr_wr_en = 1; tmr_wr_val = 0; step();
    for (int k = 0; k < 6; k++) step();
    chk(tmr_count == 0 && !pending[0], "R5", 64'(tmr_count), 64'(0));

    // R10: reload at count one pre-empts the event
    tag = "R10";
    tmr_wr_en = 1; tmr_wr_val = 2; step();
    step();
    chk(tmr_count == 1, "R10", 64'(tmr_count), 64'd1);
    tmr_wr_en = 1; tmr_wr_val = 7; step();
    chk(tmr_count == 7 && !pending[0], "R10", 64'(pending[0]), 64'(0));

    // random phase
    tag = "RND";
    for (int n = 0; n < 1500; n++) begin
      irq_lines = $urandom() & $urandom() & $urandom() & $urandom();
      ack_valid = ($urandom() % 4) == 0;
      ack_vec   = $urandom();
      tmr_wr_en = ($urandom() % 16) == 0;
      tmr_wr_val = $urandom() % 12;
      mask_wr_en = ($urandom() % 32) == 0;
      mask_wr_val = $urandom();
      if (n == 700) rst = 1;
      step();
    end

    // R8: mid-activity reset
    tag = "R8";
    irq_lines = '1; tmr_wr_en = 1; tmr_wr_val = 9; step();
    rst = 1; step();
    chk(pending == '0 && tmr_count == '0 && !irq_req, "R8", 64'(pending), 64'(0));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule